// File: doc/BRIEF.md
# Code Readout Protection and Verify Path

This block sits between a programming port and the code store of an on-chip program memory. It holds a 64-entry table of key bytes and three lock bits. It commits code bytes, key bytes and lock bits once the programming pulse has been repeated the required number of times. It serves verify reads with the code byte XNORed against a key byte picked by the low address bits. It answers signature reads with fixed identification bytes. It also turns the lock bits into protection enables for the CPU side.

A programmer selects an operation on a 3-bit mode input. It places an address and a data byte on the port, holds them for at least one cycle, and then strobes the pulse input once per cycle for each pulse. Protection grows in cumulative levels. Lock bits can only be observed through the enables they switch on. Reset returns the block to its erased state: all key bytes 0xFF and no lock bits set.

Top module: `codeguard_top`

## Requirements
- R1: With mode 2 (verify), the byte on `pg_dout` one cycle later equals the bitwise XNOR of `mem_rd_data` (read at `mem_rd_addr` = `pg_addr`) and key byte number `pg_addr[5:0]`, provided verify is not locked.
- R2: After reset, every key byte is 0xFF, so verify returns the code byte unchanged. `pg_dout` is 0xFF and all five protection outputs are low.
- R3: With mode 3 (program key), the key byte at `pg_addr[5:0]` is replaced by `pg_din` on the 25th pulse counted in an unchanged context. After 24 pulses it is unchanged.
- R4: With mode 1 (program code), the 5th counted pulse raises `mem_wr_en` for exactly one cycle, with `mem_wr_addr`/`mem_wr_data` equal to the held address and data. Four pulses write nothing.
- R5: Any change of mode, address or data restarts the pulse count. Only pulses in a context held since the previous cycle count.
- R6: Mode 4 with 25 pulses sets lock bit 1, giving level 2. `tbl_read_block`, `ea_latch_en` and `prog_lock` go high, while `verify_lock` and `ext_exec_block` stay low.
- R7: Lock bits 1 and 2 (modes 4 and 5) give level 3, which adds `verify_lock`. Verify reads then return 0xFF.
- R8: Lock bits 1, 2 and 3 (mode 6 sets bit 3) give level 4, which adds `ext_exec_block`.
- R9: Any lock-bit combination other than none, {1}, {1,2} or {1,2,3} is treated as level 4.
- R10: While `prog_lock` is high, code and key program pulses are ignored. There is no `mem_wr_en` and the key byte keeps its value. Lock-bit programming still works.
- R11: With mode 7 (signature), `pg_dout` one cycle later is 0x89 at address 0x30, 0x58 at 0x31, the `DEVICE_CODE` parameter (default 0xFC) at 0x60, and 0xFF at any other address.
- R12: In modes 0, 1, 3, 4, 5 and 6, `pg_dout` is 0xFF one cycle later.
- R13: Lock bits, once set, stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (erases keys and lock bits) |
| pg_mode | input | 3 | Operation select: 0 idle, 1 program code, 2 verify, 3 program key, 4/5/6 program lock bit 1/2/3, 7 signature |
| pg_addr | input | ADDR_W | Programming/verify address |
| pg_din | input | 8 | Byte to be programmed |
| pg_pulse | input | 1 | Program pulse, one count per high cycle |
| pg_dout | output | 8 | Registered verify/signature result |
| mem_rd_addr | output | ADDR_W | Code array read address |
| mem_rd_data | input | 8 | Code array read data, valid in the same cycle |
| mem_wr_en | output | 1 | One-cycle code array write strobe |
| mem_wr_addr | output | ADDR_W | Code array write address |
| mem_wr_data | output | 8 | Code array write data |
| tbl_read_block | output | 1 | Block table reads from external code into internal code |
| ea_latch_en | output | 1 | Latch the external-access strap at reset |
| prog_lock | output | 1 | Further code/key programming disabled |
| verify_lock | output | 1 | Verify reads disabled |
| ext_exec_block | output | 1 | Execution from external code disabled |

## Verification
The assertions assume a few things about the inputs. The code store answers `mem_rd_data` combinationally in the cycle the address is shown. Inputs change only away from the clock edge. A pulse train is applied to a context that already existed in the previous cycle, since a pulse in the cycle of a change is dropped. The stimulus keeps to these rules: it drives every input on the falling edge, it sets mode, address and data one cycle before the first pulse, and it draws random addresses and keys only inside the full address range. Every 3-bit mode value is a defined operation, so random modes need no filtering.

// File: rtl/codeguard_pkg.sv
package codeguard_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG_CODE = 3'd1,
    MODE_VERIFY    = 3'd2,
    MODE_PROG_KEY  = 3'd3,
    MODE_PROG_LB1  = 3'd4,
    MODE_PROG_LB2  = 3'd5,
    MODE_PROG_LB3  = 3'd6,
    MODE_SIGNATURE = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_NOPROG  = 2'd1,
    LVL_NOVERIF = 2'd2,
    LVL_SEALED  = 2'd3
  } lock_lvl_e;

  localparam logic [7:0] SIG_BYTE_A = 8'h89;
  localparam logic [7:0] SIG_BYTE_B = 8'h58;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  function automatic logic [7:0] key_xnor(input logic [7:0] code, input logic [7:0] key);
    return ~(code ^ key);
  endfunction

  function automatic logic is_prog_mode(input mode_e m);
    return (m == MODE_PROG_CODE) || (m == MODE_PROG_KEY) ||
           (m == MODE_PROG_LB1) || (m == MODE_PROG_LB2) || (m == MODE_PROG_LB3);
  endfunction

  function automatic int pulse_target(input mode_e m, input int code_n, input int aux_n);
    return (m == MODE_PROG_CODE) ? code_n : aux_n;
  endfunction

  function automatic logic [7:0] sig_byte(input logic [31:0] a, input logic [7:0] dev);
    logic [7:0] r;
    case (a)
      32'h30:  r = SIG_BYTE_A;
      32'h31:  r = SIG_BYTE_B;
      32'h60:  r = dev;
      default: r = BLANK_BYTE;
    endcase
    return r;
  endfunction

  function automatic lock_lvl_e decode_level(input logic [2:0] lb);
    lock_lvl_e l;
    case (lb)
      3'b000:  l = LVL_OPEN;
      3'b001:  l = LVL_NOPROG;
      3'b011:  l = LVL_NOVERIF;
      3'b111:  l = LVL_SEALED;
      default: l = LVL_SEALED;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/cg_pulse_gate.sv
module cg_pulse_gate
  import codeguard_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int CODE_PULSES = 5,
  parameter int AUX_PULSES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              pulse,
  input  logic              prog_lock,
  output logic              commit_code,
  output logic              commit_key,
  output logic [2:0]        commit_lock
);
  localparam int MAXP  = (CODE_PULSES > AUX_PULSES) ? CODE_PULSES : AUX_PULSES;
  localparam int CW    = $clog2(MAXP + 1);
  localparam int CTX_W = 3 + ADDR_W + 8;

  logic [CW-1:0]    cnt_q;
  logic [CTX_W-1:0] ctx_q;
  logic [CTX_W-1:0] ctx_now;
  logic             ctx_changed;
  logic             prog_req;
  logic             blocked;
  logic             armed;
  logic             hit;
  logic [CW-1:0]    target;

  assign ctx_now     = {mode, addr, din};
  assign ctx_changed = (ctx_now != ctx_q);
  assign prog_req    = is_prog_mode(mode);
  assign blocked     = prog_lock && ((mode == MODE_PROG_CODE) || (mode == MODE_PROG_KEY));
  assign armed       = prog_req && !blocked && !ctx_changed;
  assign target      = CW'(pulse_target(mode, CODE_PULSES, AUX_PULSES));
  assign hit         = armed && pulse && (cnt_q == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
      cnt_q <= '0;
    end else begin
      ctx_q <= ctx_now;
      if (!armed)
        cnt_q <= '0;
      else if (pulse)
        cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  assign commit_code    = hit && (mode == MODE_PROG_CODE);
  assign commit_key     = hit && (mode == MODE_PROG_KEY);
  assign commit_lock[0] = hit && (mode == MODE_PROG_LB1);
  assign commit_lock[1] = hit && (mode == MODE_PROG_LB2);
  assign commit_lock[2] = hit && (mode == MODE_PROG_LB3);

  // R3: the count never reaches the longest pulse target
  assert_cnt_below_aux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(AUX_PULSES));

  // R4: in a held code-program context the count stays under the code target
  assert_cnt_below_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROG_CODE && !ctx_changed) |-> cnt_q < CW'(CODE_PULSES));

  // R5: a context change leaves the count cleared for the next cycle
  assert_restart_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_changed |=> cnt_q == '0);

endmodule

// File: rtl/cg_key_lock_store.sv
module cg_key_lock_store #(
  parameter int KEY_DEPTH = 64,
  parameter int KEY_AW    = $clog2(KEY_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [KEY_AW-1:0] key_wr_idx,
  input  logic [7:0]        key_wr_data,
  input  logic [KEY_AW-1:0] key_rd_idx,
  output logic [7:0]        key_rd_data,
  input  logic [2:0]        lock_set,
  output logic [2:0]        lock_bits
);
  logic [7:0] key_q [KEY_DEPTH];

  for (genvar g = 0; g < KEY_DEPTH; g++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        key_q[g] <= 8'hFF;
      else if (key_we && (key_wr_idx == KEY_AW'(g)))
        key_q[g] <= key_wr_data;
    end
  end

  assign key_rd_data = key_q[key_rd_idx];

  for (genvar b = 0; b < 3; b++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lock_bits[b] <= 1'b0;
      else if (lock_set[b])
        lock_bits[b] <= 1'b1;
    end

    // R13: a set lock bit stays set
    assert_lock_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
      lock_bits[b] |=> lock_bits[b]);
  end

endmodule

// File: rtl/cg_lock_decode.sv
module cg_lock_decode
  import codeguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] lock_bits,
  output lock_lvl_e  level,
  output logic       tbl_read_block,
  output logic       ea_latch_en,
  output logic       prog_lock,
  output logic       verify_lock,
  output logic       ext_exec_block
);
  assign level          = decode_level(lock_bits);
  assign tbl_read_block = (level != LVL_OPEN);
  assign ea_latch_en    = (level != LVL_OPEN);
  assign prog_lock      = (level != LVL_OPEN);
  assign verify_lock    = (level == LVL_NOVERIF) || (level == LVL_SEALED);
  assign ext_exec_block = (level == LVL_SEALED);

  // R9: a second or third lock bit without the first means full protection
  assert_odd_combo_sealed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits[2:1] != 2'b00 && !lock_bits[0]) |-> ext_exec_block);

  // R13: protection, once granted, is not withdrawn before reset
  assert_prog_lock_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    prog_lock |=> prog_lock);

endmodule

// File: rtl/codeguard_top.sv
module codeguard_top
  import codeguard_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         KEY_DEPTH   = 64,
  parameter int         CODE_PULSES = 5,
  parameter int         AUX_PULSES  = 25,
  parameter logic [7:0] DEVICE_CODE = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pg_mode,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [7:0]        pg_din,
  input  logic              pg_pulse,
  output logic [7:0]        pg_dout,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              tbl_read_block,
  output logic              ea_latch_en,
  output logic              prog_lock,
  output logic              verify_lock,
  output logic              ext_exec_block
);
  localparam int KEY_AW = $clog2(KEY_DEPTH);

  mode_e             mode_s;
  logic              commit_code;
  logic              commit_key;
  logic [2:0]        commit_lock;
  logic [7:0]        key_byte;
  logic [2:0]        lock_bits;
  lock_lvl_e         level;
  logic [KEY_AW-1:0] key_idx;

  assign mode_s      = mode_e'(pg_mode);
  assign key_idx     = pg_addr[KEY_AW-1:0];
  assign mem_rd_addr = pg_addr;

  cg_pulse_gate #(
    .ADDR_W(ADDR_W), .CODE_PULSES(CODE_PULSES), .AUX_PULSES(AUX_PULSES)
  ) i_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode_s), .addr(pg_addr), .din(pg_din),
    .pulse(pg_pulse), .prog_lock(prog_lock),
    .commit_code(commit_code), .commit_key(commit_key), .commit_lock(commit_lock)
  );

  cg_key_lock_store #(.KEY_DEPTH(KEY_DEPTH), .KEY_AW(KEY_AW)) i_store (
    .clk(clk), .rst_n(rst_n),
    .key_we(commit_key), .key_wr_idx(key_idx), .key_wr_data(pg_din),
    .key_rd_idx(key_idx), .key_rd_data(key_byte),
    .lock_set(commit_lock), .lock_bits(lock_bits)
  );

  cg_lock_decode i_decode (
    .clk(clk), .rst_n(rst_n), .lock_bits(lock_bits), .level(level),
    .tbl_read_block(tbl_read_block), .ea_latch_en(ea_latch_en),
    .prog_lock(prog_lock), .verify_lock(verify_lock), .ext_exec_block(ext_exec_block)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_dout <= BLANK_BYTE;
    end else begin
      case (mode_s)
        MODE_VERIFY:    pg_dout <= verify_lock ? BLANK_BYTE : key_xnor(mem_rd_data, key_byte);
        MODE_SIGNATURE: pg_dout <= sig_byte(32'(pg_addr), DEVICE_CODE);
        default:        pg_dout <= BLANK_BYTE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_wr_en <= commit_code;
      if (commit_code) begin
        mem_wr_addr <= pg_addr;
        mem_wr_data <= pg_din;
      end
    end
  end

  // R7: a verify request under verify lock yields the blank byte
  assert_verify_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == MODE_VERIFY && verify_lock) |=> pg_dout == BLANK_BYTE);

  // R10: no code write follows a cycle with programming locked
  assert_no_write_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_lock |=> !mem_wr_en);

  // R4: each commit produces a single-cycle write strobe
  assert_write_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);

  // R12: non-reading modes return the blank byte
  assert_idle_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s != MODE_VERIFY && mode_s != MODE_SIGNATURE) |=> pg_dout == BLANK_BYTE);

  // R8: the sealed level implies the lower levels' enables
  assert_sealed_cumulative_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_exec_block |-> (verify_lock && prog_lock && tbl_read_block && ea_latch_en));

endmodule

// File: tb/test_codeguard_top.sv
module test_codeguard_top;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    pg_mode = 3'd0;
  logic [AW-1:0] pg_addr = '0;
  logic [7:0]    pg_din = 8'h00;
  logic          pg_pulse = 1'b0;
  logic [7:0]    pg_dout;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0]    mem_wr_data;
  logic          tbl_read_block, ea_latch_en, prog_lock, verify_lock, ext_exec_block;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] keys [64];
  logic [AW-1:0] last_wa;
  logic [7:0]    last_wd;

  always #10 clk = ~clk;

  codeguard_top i_codeguard_top (
    .clk(clk), .rst_n(rst_n), .pg_mode(pg_mode), .pg_addr(pg_addr), .pg_din(pg_din),
    .pg_pulse(pg_pulse), .pg_dout(pg_dout), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .tbl_read_block(tbl_read_block), .ea_latch_en(ea_latch_en),
    .prog_lock(prog_lock), .verify_lock(verify_lock), .ext_exec_block(ext_exec_block)
  );

  function automatic logic [7:0] code_fn(input logic [AW-1:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return (a[3:0] == 4'h0) ? 8'hFF : (m ^ {a[14:8], 1'b1});
  endfunction

  assign mem_rd_data = code_fn(mem_rd_addr);

  function automatic logic [7:0] exp_verify(input logic [AW-1:0] a);
    return ~(code_fn(a) ^ keys[a[5:0]]);
  endfunction

  function automatic logic [7:0] exp_sig(input logic [AW-1:0] a);
    if (a == 15'h30) return 8'h89;
    if (a == 15'h31) return 8'h58;
    if (a == 15'h60) return 8'hFC;
    return 8'hFF;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_perm(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {tbl_read_block, ea_latch_en, prog_lock, verify_lock, ext_exec_block};
    chk(act == exp, req, 32'(act), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pg_mode = 3'd0; pg_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) keys[i] = 8'hFF;
    @(negedge clk);
  endtask

  task automatic do_program(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                            input int n, output int writes);
    @(negedge clk);
    pg_mode = m; pg_addr = a; pg_din = d; pg_pulse = 1'b0;
    @(negedge clk);
    writes = 0;
    for (int i = 0; i < n; i++) begin
      pg_pulse = 1'b1;
      @(negedge clk);
      pg_pulse = 1'b0;
      if (mem_wr_en) begin
        writes++;
        last_wa = mem_wr_addr;
        last_wd = mem_wr_data;
      end
    end
  endtask

  task automatic do_read(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    pg_mode = m; pg_addr = a; pg_pulse = 1'b0;
    @(negedge clk);
    d = pg_dout;
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    int w;
    logic [7:0] d;
    logic [AW-1:0] a;
    logic [7:0] kv;
    seed_init = $urandom(32'hC0DE51);

    do_reset();
    // R2: reset state
    chk(pg_dout == 8'hFF, "R2 dout after reset", 32'(pg_dout), 32'hFF);
    chk_perm("R2 permissions after reset", 5'b00000);
    for (int i = 0; i < 30; i++) begin
      a = AW'($urandom);
      do_read(3'd2, a, d);
      chk(d == code_fn(a), "R2 erased keys return code", 32'(d), 32'(code_fn(a)));
    end

    // R3: 24 pulses do not commit, the 25th does
    do_program(3'd3, 15'h0005, 8'h3C, 24, w);
    do_read(3'd2, 15'h0005, d);
    chk(d == exp_verify(15'h0005), "R3 key unchanged after 24 pulses", 32'(d), 32'(exp_verify(15'h0005)));
    do_program(3'd3, 15'h0005, 8'h3C, 25, w);
    keys[5] = 8'h3C;
    do_read(3'd2, 15'h0005, d);
    chk(d == exp_verify(15'h0005), "R3 key written after 25 pulses", 32'(d), 32'(exp_verify(15'h0005)));
    // R3: FF code byte reads back as the key itself (address with low nibble 0)
    do_program(3'd3, 15'h0010, 8'hA7, 25, w);
    keys[16] = 8'hA7;
    do_read(3'd2, 15'h0010, d);
    chk(d == 8'hA7, "R3 blank code reads key", 32'(d), 32'hA7);

    for (int i = 0; i < 8; i++) begin
      a = AW'($urandom);
      kv = 8'($urandom);
      do_program(3'd3, a, kv, 25, w);
      keys[a[5:0]] = kv;
    end
    // R1: randomized verify reads
    for (int i = 0; i < 60; i++) begin
      a = AW'($urandom);
      if (i % 4 == 0) a[5:0] = 6'd5;
      do_read(3'd2, a, d);
      chk(d == exp_verify(a), "R1 verify xnor", 32'(d), 32'(exp_verify(a)));
    end

    // R4: code programming pulse count
    do_program(3'd1, 15'h1234, 8'h5A, 4, w);
    chk(w == 0, "R4 no write after 4 pulses", 32'(w), 0);
    do_program(3'd1, 15'h1234, 8'h5A, 1, w);
    chk(w == 1, "R4 write on 5th pulse", 32'(w), 1);
    chk(last_wa == 15'h1234 && last_wd == 8'h5A, "R4 write address/data",
        {9'd0, last_wa, last_wd}, {9'd0, 15'h1234, 8'h5A});
    for (int i = 0; i < 5; i++) begin
      a = AW'($urandom); kv = 8'($urandom);
      do_program(3'd1, a, kv, 7, w);
      chk(w == 1 && last_wa == a && last_wd == kv, "R4 random code write",
          {9'd0, last_wa, last_wd}, {9'd0, a, kv});
    end

    // R5: a context change restarts the count
    do_program(3'd1, 15'h0400, 8'h11, 3, w);
    do_program(3'd1, 15'h0400, 8'h22, 4, w);
    chk(w == 0, "R5 data change restarts count", 32'(w), 0);
    do_program(3'd1, 15'h0400, 8'h22, 1, w);
    chk(w == 1 && last_wd == 8'h22, "R5 commit after held pulses", 32'(last_wd), 32'h22);

    // R11: signature bytes
    do_read(3'd7, 15'h0030, d); chk(d == 8'h89, "R11 signature 30h", 32'(d), 32'h89);
    do_read(3'd7, 15'h0031, d); chk(d == 8'h58, "R11 signature 31h", 32'(d), 32'h58);
    do_read(3'd7, 15'h0060, d); chk(d == 8'hFC, "R11 signature 60h", 32'(d), 32'hFC);
    for (int i = 0; i < 10; i++) begin
      a = AW'($urandom);
      do_read(3'd7, a, d);
      chk(d == exp_sig(a), "R11 signature other", 32'(d), 32'(exp_sig(a)));
    end

    // R12: other modes return blank
    for (int m = 0; m < 7; m++) begin
      if (m == 2) continue;
      do_read(3'(m), AW'($urandom), d);
      chk(d == 8'hFF, "R12 blank in non-read mode", 32'(d), 32'hFF);
    end

    // R9: lock bit 2 alone is fully sealed
    do_program(3'd5, 15'h0, 8'h0, 25, w);
    chk_perm("R9 undefined combo sealed", 5'b11111);
    do_read(3'd2, 15'h0005, d);
    chk(d == 8'hFF, "R9 verify blank when sealed", 32'(d), 32'hFF);
    repeat (20) @(negedge clk);
    chk_perm("R13 lock held over idle cycles", 5'b11111);

    do_reset();
    // R6: level 2
    do_program(3'd4, 15'h0, 8'h0, 25, w);
    chk_perm("R6 level 2 enables", 5'b11100);
    do_read(3'd2, 15'h0123, d);
    chk(d == exp_verify(15'h0123), "R6 verify still open", 32'(d), 32'(exp_verify(15'h0123)));
    // R10: program requests ignored
    do_program(3'd1, 15'h0222, 8'h44, 10, w);
    chk(w == 0, "R10 code write blocked", 32'(w), 0);
    do_program(3'd3, 15'h0005, 8'h00, 30, w);
    do_read(3'd2, 15'h0005, d);
    chk(d == exp_verify(15'h0005), "R10 key unchanged", 32'(d), 32'(exp_verify(15'h0005)));

    // R7: level 3
    do_program(3'd5, 15'h0, 8'h0, 25, w);
    chk_perm("R7 level 3 enables", 5'b11110);
    do_read(3'd2, 15'h0123, d);
    chk(d == 8'hFF, "R7 verify blank", 32'(d), 32'hFF);

    // R8: level 4
    do_program(3'd6, 15'h0, 8'h0, 25, w);
    chk_perm("R8 level 4 enables", 5'b11111);
    do_read(3'd7, 15'h0030, d);
    chk(d == 8'h89, "R8 signature unaffected", 32'(d), 32'h89);

    @(negedge clk);
    pg_mode = 3'd0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule